// File: doc/BRIEF.md
# Programmable Synchronous Serial Port Master

This block is a register-mapped serial master for driving display controllers and similar slave devices over a four-wire serial link. Software reaches it through a simple 32-bit word-addressed register bus. It writes frame words into a small transmit queue. The block shifts each word out on the serial data output while it samples the serial data input into a receive queue. Each frame is 4 to 16 bits wide. The clock polarity and phase can be set, and the bit order can be most- or least-significant first.

The serial clock comes from two dividers in series. The first is an even prescaler. The second is a rate factor, so one half period of the serial clock lasts (prescaler/2)·(1 + rate) bus cycles. The active-low select stays asserted across back-to-back frames for as long as the transmit queue holds data. After the last frame it is released one serial clock period later. A write-only mode discards received data. A small interrupt set (receive overrun, receive not empty, transmit empty) is combined through a mask into one request line.

A common use is a 9-bit frame that carries a command/data flag in bit 8 above an 8-bit payload. The flag is 0 for a command and 1 for data, and it leaves first when the port is most-significant first.

Top module: `ssp_master`

## Requirements
- R1: After reset the select output is high, the serial clock is low, the interrupt line is low, and the status word (offset 0x0C) reads 0x03. Status bits are: [0] transmit queue empty, [1] transmit queue not full, [2] receive queue not empty, [3] receive queue full, [4] busy.
- R2: Control-0 (offset 0x00, 16 bits) and DMA control (offset 0x24, 2 bits) read back as written. The prescaler (offset 0x10, 8 bits) reads back with bit 0 forced to zero.
- R3: Control-0 bits [3:0] hold the frame width minus one, and codes below 3 give 4 bits. With control-1 bit 4 clear, each frame is sent most-significant bit first, so a 9-bit word sends its bit 8 (the command/data flag) first.
- R4: With control-1 bit 4 set, each frame is sent and assembled least-significant bit first.
- R5: While a frame is in flight, the serial clock toggles every (P/2)·(1+S) bus cycles. P is the prescaler value and S is control-0 bits [15:8].
- R6: When control-0 bits [5:4] are zero, bit 6 sets the idle clock level and bit 7 set means data is captured on the trailing edge instead of the leading edge. For any other format code, both bits are ignored and the port runs with idle-low clock and leading-edge capture.
- R7: The serial input is captured on the capture edge of each bit and assembled into a word. Reading the data register (offset 0x08) pops the receive queue and returns the word zero-extended.
- R8: With control-1 bit 5 set, received frames are discarded and the receive queue stays empty.
- R9: The select stays low between back-to-back queued frames. It rises two half periods after the final clock edge of the last frame.
- R10: With control-1 bit 1 clear, no frame starts, the select stays high and written words stay queued. Setting the bit starts sending them.
- R11: Writes to the data register while the transmit queue is full are dropped. The queue then holds exactly its depth of words.
- R12: Raw interrupt status (offset 0x18) is {tx empty, rx not empty, overrun} in bits [2:0]. Overrun is set when a frame completes while the receive queue is full, and it stays set until a 1 is written to bit 0 of offset 0x20. The masked status (0x1C) is raw AND mask (0x14), and the interrupt line is the OR of the masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive queue at data offset) |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Combined masked interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low slave select |

## Verification
The bench attaches a slave model that captures the output on the capture edge selected by the expected mode and returns its own word on the input. It sweeps all four polarity/phase combinations plus a non-zero format code with the mode bits set. A design that ignored the format code would idle the clock high there and shift data on the wrong edge. In back-to-back traffic it counts select releases and measures the release delay, which catches a select that drops between frames or is released too early. It also fills the transmit queue while the port is disabled and then overfills the receive queue. A design that accepted writes beyond the queue depth would send too many frames, and one whose overrun flag were not sticky would lose it before software cleared it.

// File: rtl/ssp_pkg.sv
// Shared definitions for the serial port master: register offsets and
// the frame engine state encoding. Assumes byte offsets on a word bus.
package ssp_pkg;

    localparam logic [5:0] OFS_CTL0  = 6'h00;
    localparam logic [5:0] OFS_CTL1  = 6'h04;
    localparam logic [5:0] OFS_DATA  = 6'h08;
    localparam logic [5:0] OFS_STAT  = 6'h0C;
    localparam logic [5:0] OFS_PRE   = 6'h10;
    localparam logic [5:0] OFS_MASK  = 6'h14;
    localparam logic [5:0] OFS_RAW   = 6'h18;
    localparam logic [5:0] OFS_MSKD  = 6'h1C;
    localparam logic [5:0] OFS_CLR   = 6'h20;
    localparam logic [5:0] OFS_DMA   = 6'h24;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TAIL = 2'd2
    } frm_state_t;

endpackage

// File: rtl/ssp_fifo.sv
// Synchronous first-in first-out queue with occupancy count.
// Assumes push and pop in the same cycle are both honoured when legal;
// a push into a full queue and a pop from an empty queue are ignored.
module ssp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R11: a push into a full queue without a pop leaves occupancy unchanged
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));

    // R11: occupancy never exceeds the depth
    assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R7: a pop from an empty queue without a push leaves it empty
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/ssp_clkgen.sv
// Serial clock edge generator. Produces a one-cycle tick every
// (prescale/2)*(1+rate) bus cycles while run is high; each tick marks
// one serial clock edge. Assumes prescale is even; values below 2 act as 2.
module ssp_clkgen #(
    parameter int PW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] prescale,
    input  logic [SW-1:0] rate,
    output logic          tick
);
    localparam int HW = PW + SW;

    logic [PW-2:0] pre_half;
    logic [HW-1:0] half_len;
    logic [HW-1:0] cnt;

    // Half period length in bus cycles.
    always_comb begin
        pre_half = (prescale[PW-1:1] == '0) ? (PW-1)'(1) : prescale[PW-1:1];
        half_len = {{(SW+1){1'b0}}, pre_half} * ({{PW{1'b0}}, rate} + HW'(1));
    end

    assign tick = run && (cnt == half_len - HW'(1));

    // Count bus cycles within one half period; restart when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    // R5: the half-period counter stays below its terminal value
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < half_len));

endmodule

// File: rtl/ssp_frame.sv
// Frame engine: takes words from the transmit queue, drives the serial
// clock, data out and select, and assembles captured input bits.
// Assumes configuration is held stable while a frame is in flight and
// that nbits lies in 4..MAXW.
module ssp_frame
    import ssp_pkg::*;
#(
    parameter int MAXW = 16,
    localparam int NW  = $clog2(MAXW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            cpol,
    input  logic            cpha,
    input  logic            lsb_first,
    input  logic            wr_only,
    input  logic [NW-1:0]   nbits,
    input  logic            tick,
    input  logic            tx_empty,
    input  logic [MAXW-1:0] tx_data,
    input  logic            miso,
    output logic            tx_pop,
    output logic            rx_push,
    output logic [MAXW-1:0] rx_data,
    output logic            run,
    output logic            sclk,
    output logic            mosi,
    output logic            cs_n
);
    localparam int EW = NW + 1;

    frm_state_t      state;
    logic [MAXW-1:0] cur;
    logic [MAXW-1:0] rxacc;
    logic [EW-1:0]   e;
    logic [EW-1:0]   last_e, e_m1;
    logic [NW-1:0]   o_idx, s_idx, o_pos, s_pos;
    logic [MAXW-1:0] out_sh, rmask, rx_next;
    logic            is_last, samp_now, more, end_frame;

    // Edge bookkeeping and bit positions for output and capture.
    always_comb begin
        last_e  = {nbits, 1'b0} - EW'(1);
        is_last = (e == last_e);
        e_m1    = e - EW'(1);
        s_idx   = e[EW-1:1];
        if (cpha) o_idx = (e == '0) ? '0 : e_m1[EW-1:1];
        else      o_idx = e[EW-1:1];
        o_pos   = lsb_first ? o_idx : (nbits - NW'(1) - o_idx);
        s_pos   = lsb_first ? s_idx : (nbits - NW'(1) - s_idx);
        out_sh  = cur >> o_pos;
        rmask   = MAXW'(1) << s_pos;
    end

    // Capture logic and queue handshakes.
    always_comb begin
        samp_now  = (state == ST_XFER) && enable && tick && (e[0] == cpha);
        if (samp_now) rx_next = miso ? (rxacc | rmask) : (rxacc & ~rmask);
        else          rx_next = rxacc;
        more      = enable && !tx_empty;
        end_frame = (state == ST_XFER) && enable && tick && is_last;
        tx_pop    = ((state == ST_IDLE) && more) || (end_frame && more);
        rx_push   = end_frame && !wr_only;
    end

    assign rx_data = rx_next;
    assign run     = (state != ST_IDLE);
    assign cs_n    = (state == ST_IDLE);
    assign mosi    = (state == ST_XFER) ? out_sh[0] : 1'b0;

    // Sequence frames: start, edge stepping, chaining and release delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur   <= '0;
            rxacc <= '0;
            e     <= '0;
            sclk  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    sclk  <= cpol;
                    e     <= '0;
                    rxacc <= '0;
                    if (more) begin
                        cur   <= tx_data;
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (!enable) begin
                        state <= ST_IDLE;
                        sclk  <= cpol;
                    end else if (tick) begin
                        sclk  <= ~sclk;
                        rxacc <= rx_next;
                        if (is_last) begin
                            e     <= '0;
                            rxacc <= '0;
                            if (more) cur <= tx_data;
                            else      state <= ST_TAIL;
                        end else begin
                            e <= e + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (!enable) begin
                        state <= ST_IDLE;
                        sclk  <= cpol;
                    end else if (tick) begin
                        if (e == EW'(1)) state <= ST_IDLE;
                        else             e <= e + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: clearing the enable releases the select on the next cycle
    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> cs_n);

    // R6: an idle port holds the clock at the configured idle level
    assert_idle_polarity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $stable(cpol)) |-> (sclk == cpol));

    // R5: the serial clock moves only on a divider tick during a frame
    assert_sclk_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_XFER) && enable && !tick) |=> $stable(sclk));

    // R9: while chaining frames the select does not rise
    assert_chain_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (end_frame && more) |=> !cs_n);

endmodule

// File: rtl/ssp_master.sv
// Register-mapped synchronous serial master. Holds the register bank,
// two queues, the clock divider and the frame engine. Assumes bus
// accesses are single-cycle strobes; reads are combinational and a read
// of the data offset pops the receive queue at the clock edge.
module ssp_master
    import ssp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n
);
    localparam int MAXW = 16;
    localparam int NW   = $clog2(MAXW + 1);
    localparam int PW   = 8;
    localparam int SW   = 8;

    logic [15:0]     ctl0_q, ctl1_q;
    logic [PW-1:0]   pre_q;
    logic [2:0]      mask_q;
    logic [1:0]      dma_q;
    logic            ovr_q;

    logic            fmt_spi, cpol, cpha, enable, lsb_first, wr_only;
    logic [NW-1:0]   nbits;
    logic [MAXW-1:0] wmask;
    logic            tx_push, tx_pop, tx_full, tx_empty;
    logic            rx_push, rx_pop, rx_full, rx_empty;
    logic [MAXW-1:0] tx_head, rx_head, rx_word;
    logic            run, tick, clr_ovr;
    logic [4:0]      status;
    logic [2:0]      raw_irq, msk_irq;

    // Decode the configuration fields from the control registers.
    always_comb begin
        fmt_spi   = (ctl0_q[5:4] == 2'b00);
        cpol      = fmt_spi && ctl0_q[6];
        cpha      = fmt_spi && ctl0_q[7];
        nbits     = (ctl0_q[3:0] < 4'd3) ? NW'(4) : (NW'(ctl0_q[3:0]) + NW'(1));
        enable    = ctl1_q[1];
        lsb_first = ctl1_q[4];
        wr_only   = ctl1_q[5];
        wmask     = {MAXW{1'b1}} >> (NW'(MAXW) - nbits);
    end

    assign tx_push = bus_wr && (bus_addr == OFS_DATA);
    assign rx_pop  = bus_rd && (bus_addr == OFS_DATA);
    assign clr_ovr = bus_wr && (bus_addr == OFS_CLR) && bus_wdata[0];

    // Register writes from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0_q <= '0;
            ctl1_q <= '0;
            pre_q  <= '0;
            mask_q <= '0;
            dma_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTL0: ctl0_q <= bus_wdata[15:0];
                OFS_CTL1: ctl1_q <= bus_wdata[15:0];
                OFS_PRE:  pre_q  <= {bus_wdata[PW-1:1], 1'b0};
                OFS_MASK: mask_q <= bus_wdata[2:0];
                OFS_DMA:  dma_q  <= bus_wdata[1:0];
                default:  ;
            endcase
        end
    end

    // Sticky receive overrun flag; a new overrun wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ovr_q <= 1'b0;
        else if (rx_push && rx_full)  ovr_q <= 1'b1;
        else if (clr_ovr)             ovr_q <= 1'b0;
    end

    // Status and interrupt composition.
    always_comb begin
        status  = {run || !tx_empty, rx_full, !rx_empty, !tx_full, tx_empty};
        raw_irq = {tx_empty, !rx_empty, ovr_q};
        msk_irq = raw_irq & mask_q;
    end

    assign irq = |msk_irq;

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            OFS_CTL0: bus_rdata = {16'h0, ctl0_q};
            OFS_CTL1: bus_rdata = {16'h0, ctl1_q};
            OFS_DATA: bus_rdata = rx_empty ? 32'h0 : {{(32-MAXW){1'b0}}, rx_head};
            OFS_STAT: bus_rdata = {27'h0, status};
            OFS_PRE:  bus_rdata = {{(32-PW){1'b0}}, pre_q};
            OFS_MASK: bus_rdata = {29'h0, mask_q};
            OFS_RAW:  bus_rdata = {29'h0, raw_irq};
            OFS_MSKD: bus_rdata = {29'h0, msk_irq};
            OFS_DMA:  bus_rdata = {30'h0, dma_q};
            default:  bus_rdata = 32'h0;
        endcase
    end

    ssp_fifo #(.WIDTH(MAXW), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (bus_wdata[MAXW-1:0] & wmask),
        .pop   (tx_pop),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    ssp_fifo #(.WIDTH(MAXW), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_pop),
        .rdata (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    ssp_clkgen #(.PW(PW), .SW(SW)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .prescale (pre_q),
        .rate     (ctl0_q[15:8]),
        .tick     (tick)
    );

    ssp_frame #(.MAXW(MAXW)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cpol      (cpol),
        .cpha      (cpha),
        .lsb_first (lsb_first),
        .wr_only   (wr_only),
        .nbits     (nbits),
        .tick      (tick),
        .tx_empty  (tx_empty),
        .tx_data   (tx_head),
        .miso      (miso),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .rx_data   (rx_word),
        .run       (run),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_n      (cs_n)
    );

    // R12: overrun stays set unless software clears it
    assert_ovr_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clr_ovr) |=> ovr_q);

    // R8: in write-only mode the receive queue never gains an entry
    assert_wronly_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_only && rx_empty && !bus_wr) |=> rx_empty);

endmodule

// File: tb/tb_ssp_master.sv
`timescale 1ns/1ps
// Directed bench for the serial port master with a behavioural slave.
module tb_ssp_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sclk, mosi, miso, cs_n;

    int checks = 0, errors = 0;
    bit done = 0;

    // slave model state
    logic [63:0] cap;
    int          cap_n;
    logic [63:0] slv;
    int          si;
    logic        cpol_exp = 0, cpha_exp = 0;
    logic        prev_sclk = 0, prev_cs = 1, prev_mosi = 0;
    int          cyc = 0, last_tog = 0, iv_min, iv_max, cs_rises, tail_gap;
    bit          have_tog = 0;

    ssp_master dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign miso = (si >= 0 && si < 64) ? slv[63 - si] : 1'b0;

    // Slave: capture data on the expected capture edge, measure timing.
    always @(negedge clk) begin
        if (!cs_n && prev_cs) have_tog = 0;
        if (!cs_n && sclk != prev_sclk) begin
            if ((prev_sclk == cpol_exp) != cpha_exp) begin
                cap = {cap[62:0], prev_mosi};
                cap_n++;
                si++;
            end
            if (have_tog) begin
                if (cyc - last_tog < iv_min) iv_min = cyc - last_tog;
                if (cyc - last_tog > iv_max) iv_max = cyc - last_tog;
            end
            have_tog = 1;
            last_tog = cyc;
        end
        if (cs_n && !prev_cs) begin
            cs_rises++;
            tail_gap = cyc - last_tog;
        end
        prev_sclk = sclk;
        prev_cs   = cs_n;
        prev_mosi = mosi;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic clear_mon(input logic [63:0] sword, input int n);
        cap = '0; cap_n = 0; si = 0;
        slv = sword << (64 - n);
        iv_min = 1 << 30; iv_max = 0; cs_rises = 0; tail_gap = -1;
    endtask

    task automatic cfg(input logic [15:0] c0, input logic [7:0] pre, input logic [15:0] c1,
                       input logic epol, input logic epha);
        wr(6'h04, 32'h0);
        wr(6'h00, {16'h0, c0});
        wr(6'h10, {24'h0, pre});
        cpol_exp = epol; cpha_exp = epha;
        wr(6'h04, {16'h0, c1});
    endtask

    task automatic wait_done;
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(6'h0C, s);
            if (!s[4]) break;
        end
    endtask

    function automatic logic [15:0] rev(input logic [15:0] v, input int n);
        logic [15:0] r = '0;
        for (int i = 0; i < n; i++) r[n-1-i] = v[i];
        return r;
    endfunction

    // One frame exchange with checks on sent and received words.
    task automatic xfer(input string req, input int n, input logic [15:0] w,
                        input logic [15:0] sw, input bit lsb, input bit chk_rx);
        logic [31:0] d;
        logic [15:0] msk = 16'hFFFF >> (16 - n);
        clear_mon({48'h0, sw}, n);
        wr(6'h08, {16'h0, w});
        wait_done();
        chk({req, " sent"}, cap[15:0] & msk, lsb ? rev(w, n) : (w & msk));
        chk({req, " bits"}, cap_n, n);
        chk({req, " idle clk"}, sclk, cpol_exp);
        rd(6'h08, d);
        if (chk_rx) chk({req, " rx"}, d, {16'h0, lsb ? rev(sw, n) : (sw & msk)});
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sclk", sclk, 0);
        chk("R1 irq", irq, 0);
        rd(6'h0C, d);
        chk("R1 status", d, 32'h3);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(6'h00, 32'h0807); rd(6'h00, d); chk("R2 ctl0", d, 32'h0807);
        wr(6'h10, 32'h09);   rd(6'h10, d); chk("R2 prescaler even", d, 32'h08);
        wr(6'h24, 32'h3);    rd(6'h24, d); chk("R2 dma", d, 32'h3);
    endtask

    task automatic t_cmd9;
        // R3: 9-bit data word, flag bit 8 = 1 goes first; R7 receive
        cfg(16'h0008, 8'd2, 16'h0002, 0, 0);
        xfer("R3 9-bit data", 9, 16'h1A5, 16'h0C3, 0, 1);
        chk("R3 flag first", cap[8], 1);
        chk("R5 half period P2 S0", iv_max, 1);
        xfer("R7 9-bit command", 9, 16'h03C, 16'h1F0, 0, 1);
        chk("R3 cmd flag first", cap[8], 0);
    endtask

    task automatic t_rate;
        cfg(16'h020F, 8'd4, 16'h0002, 0, 0);
        xfer("R5 16-bit", 16, 16'hA55A, 16'h5AA5, 0, 1);
        chk("R5 min half period", iv_min, 6);
        chk("R5 max half period", iv_max, 6);
    endtask

    task automatic t_modes;
        for (int m = 0; m < 4; m++) begin
            cfg({8'h01, m[1], m[0], 6'h07}, 8'd2, 16'h0002, m[0], m[1]);
            xfer($sformatf("R6 mode %0d", m), 8, 16'h96 ^ 16'(m), 16'h3C ^ 16'(m), 0, 1);
        end
        // non-zero format: polarity/phase bits ignored
        cfg(16'h01D7, 8'd2, 16'h0002, 0, 0);
        xfer("R6 format 1 ignores mode", 8, 16'hC5, 16'h6B, 0, 1);
    endtask

    task automatic t_lsb;
        cfg(16'h0003, 8'd2, 16'h0012, 0, 0);
        xfer("R4 lsb 4-bit", 4, 16'h000B, 16'h0006, 1, 1);
        cfg(16'h000B, 8'd2, 16'h0012, 0, 0);
        xfer("R4 lsb 12-bit", 12, 16'h0E31, 16'h0A5C, 1, 1);
    endtask

    task automatic t_wronly;
        logic [31:0] d;
        cfg(16'h0007, 8'd2, 16'h0022, 0, 0);
        clear_mon(64'hFF, 8);
        wr(6'h08, 32'h5A);
        wait_done();
        chk("R8 sent", cap[7:0], 8'h5A);
        rd(6'h0C, d);
        chk("R8 rx empty", d[2], 0);
    endtask

    task automatic t_b2b;
        cfg(16'h0107, 8'd2, 16'h0002, 0, 0);
        clear_mon(64'h0, 8);
        wr(6'h04, 32'h0);
        wr(6'h08, 32'h11); wr(6'h08, 32'h22); wr(6'h08, 32'h33);
        wr(6'h04, 32'h2);
        wait_done();
        chk("R9 three frames", cap[23:0], 24'h112233);
        chk("R9 single select release", cs_rises, 1);
        chk("R9 release delay", tail_gap, 4);
        for (int i = 0; i < 3; i++) begin
            logic [31:0] d;
            rd(6'h08, d);
        end
    endtask

    task automatic t_disable;
        logic [31:0] d;
        cfg(16'h0007, 8'd2, 16'h0000, 0, 0);
        clear_mon(64'h0, 8);
        wr(6'h08, 32'hE7);
        repeat (40) @(negedge clk);
        chk("R10 cs_n high", cs_n, 1);
        chk("R10 no bits", cap_n, 0);
        rd(6'h0C, d);
        chk("R10 queued", d[0], 0);
        wr(6'h04, 32'h2);
        wait_done();
        chk("R10 sent after enable", cap[7:0], 8'hE7);
        rd(6'h08, d);
    endtask

    task automatic t_full_ovr;
        logic [31:0] d;
        int nrd;
        cfg(16'h0007, 8'd2, 16'h0000, 0, 0);
        clear_mon(64'h0, 8);
        for (int i = 0; i < 10; i++) wr(6'h08, 32'(i + 1));
        rd(6'h0C, d);
        chk("R11 tx full", d[1], 0);
        wr(6'h04, 32'h2);
        wait_done();
        chk("R11 frames sent", cap_n, 64);
        rd(6'h0C, d);
        chk("R11 rx full", d[3], 1);
        wr(6'h14, 32'h1);
        chk("R12 irq idle", irq, 0);
        wr(6'h08, 32'h99);
        wait_done();
        rd(6'h18, d);
        chk("R12 overrun raw", d[0], 1);
        chk("R12 irq", irq, 1);
        rd(6'h1C, d);
        chk("R12 masked", d, 32'h1);
        wr(6'h20, 32'h1);
        rd(6'h18, d);
        chk("R12 cleared", d[0], 0);
        chk("R12 irq cleared", irq, 0);
        nrd = 0;
        for (int i = 0; i < 12; i++) begin
            rd(6'h0C, d);
            if (!d[2]) break;
            rd(6'h08, d);
            nrd++;
        end
        chk("R11 rx depth", nrd, 8);
    endtask

    initial begin
        clear_mon(64'h0, 8);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_cmd9();
        t_rate();
        t_modes();
        t_lsb();
        t_wronly();
        t_b2b();
        t_disable();
        t_full_ovr();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule